// File: doc/BRIEF.md
# Byte-Controlled Bidirectional Latched Transceiver

This block sits between two 16-bit ports, A and B. It is split into two 8-bit lanes. Each lane has two storage banks, one for each direction of data flow.

For each lane and each direction there are three active-low controls:
- a chip enable,
- a latch enable,
- an output enable.

While both the chip enable and the latch enable of a direction are low, that lane's bank is transparent: the opposite port shows the incoming data, unchanged. When the latch enable goes high, the bank keeps the last value it took and ignores later input changes. While the chip enable is high, the bank holds its value whatever the latch enable does. The outgoing port of a lane is driven only while both the chip enable and the output enable of that direction are low.

The bidirectional pins are modelled as separate input, output and per-bit output-enable vectors for each port. Storage is implemented as clocked registers. A bank that is open passes its input straight to the output in the same cycle, and takes that value into storage at every rising clock edge while it stays open. The value held after the latch enable rises is therefore the input sampled at the last clock edge on which the bank was open.

Top module: `xcvr_byte_latch`

## Requirements
- R1: While rstN is low, both banks of every lane clear to zero. Reading a bank with its chip enable low, its latch enable high and its output enable low then gives 0x00 on that lane.
- R2: In a lane where ceAbN and leAbN are both low, bOut for that lane equals aIn for that lane in the same cycle, bit for bit and without inversion.
- R3: After leAbN of a lane rises, bOut for that lane keeps the aIn value sampled at the last clock edge on which the lane was open. Later changes on aIn have no effect on it.
- R4: While ceAbN of a lane is high, the A-to-B bank of that lane holds its value whatever the level of leAbN.
- R5: All 8 bits of bOe for a lane are 1 when both ceAbN and oeAbN of that lane are low. Otherwise all 8 bits are 0.
- R6: The B-to-A direction obeys R2 to R5 with ceBaN, leBaN and oeBaN, bIn as input, and aOut/aOe as outputs.
- R7: The controls of lane 0 (bits 7:0, control bit 0) have no effect on lane 1 (bits 15:8, control bit 1), and the reverse holds too. Likewise, activity in one direction never changes the bank of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aIn | input | 16 | Data arriving on port A |
| bIn | input | 16 | Data arriving on port B |
| ceAbN | input | 2 | A-to-B chip enable per lane, active low |
| leAbN | input | 2 | A-to-B latch enable per lane, active low |
| oeAbN | input | 2 | A-to-B output enable per lane, active low |
| ceBaN | input | 2 | B-to-A chip enable per lane, active low |
| leBaN | input | 2 | B-to-A latch enable per lane, active low |
| oeBaN | input | 2 | B-to-A output enable per lane, active low |
| aOut | output | 16 | Data driven onto port A |
| aOe | output | 16 | Per-bit drive enable for port A |
| bOut | output | 16 | Data driven onto port B |
| bOe | output | 16 | Per-bit drive enable for port B |

## Verification
The bench builds the block with its default two lanes of eight bits. Two lanes are the fewest that let cross-lane independence be shown: one lane is opened, held or floated while the other is frozen. Eight-bit lanes let each lane carry a distinct pattern, so a value that leaks into the wrong lane or the wrong direction shows up. Random control mixes cover every combination of chip, latch and output enable in both directions at once.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int DEF_LANES  = 2;
  localparam int DEF_LANE_W = 8;

  typedef struct packed {
    logic abOpen;
    logic abDrive;
    logic baOpen;
    logic baDrive;
  } laneStrobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
#(
  parameter int LANES = DEF_LANES
) (
  input  logic [LANES-1:0] ceAbN,
  input  logic [LANES-1:0] leAbN,
  input  logic [LANES-1:0] oeAbN,
  input  logic [LANES-1:0] ceBaN,
  input  logic [LANES-1:0] leBaN,
  input  logic [LANES-1:0] oeBaN,
  output laneStrobe_t [LANES-1:0] strobes
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      strobes[l].abOpen  = !ceAbN[l] && !leAbN[l];
      strobes[l].abDrive = !ceAbN[l] && !oeAbN[l];
      strobes[l].baOpen  = !ceBaN[l] && !leBaN[l];
      strobes[l].baDrive = !ceBaN[l] && !oeBaN[l];
    end
  end
endmodule

// File: rtl/xcvr_lane_latch.sv
module xcvr_lane_latch #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              open,
  input  logic              drive,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout,
  output logic [LANE_W-1:0] oe
);
  logic [LANE_W-1:0] held;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     held <= '0;
    else if (open) held <= din;
  end

  assign dout = open ? din : held;
  assign oe   = {LANE_W{drive}};
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int LANES  = DEF_LANES,
  parameter int LANE_W = DEF_LANE_W,
  localparam int BUS_W = LANES * LANE_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  laneStrobe_t [LANES-1:0] strobes,
  input  logic [BUS_W-1:0]        aIn,
  input  logic [BUS_W-1:0]        bIn,
  output logic [BUS_W-1:0]        aOut,
  output logic [BUS_W-1:0]        aOe,
  output logic [BUS_W-1:0]        bOut,
  output logic [BUS_W-1:0]        bOe
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    xcvr_lane_latch #(.LANE_W(LANE_W)) u_ab (
      .clk  (clk),
      .rstN (rstN),
      .open (strobes[l].abOpen),
      .drive(strobes[l].abDrive),
      .din  (aIn[l*LANE_W +: LANE_W]),
      .dout (bOut[l*LANE_W +: LANE_W]),
      .oe   (bOe[l*LANE_W +: LANE_W])
    );
    xcvr_lane_latch #(.LANE_W(LANE_W)) u_ba (
      .clk  (clk),
      .rstN (rstN),
      .open (strobes[l].baOpen),
      .drive(strobes[l].baDrive),
      .din  (bIn[l*LANE_W +: LANE_W]),
      .dout (aOut[l*LANE_W +: LANE_W]),
      .oe   (aOe[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/xcvr_byte_latch.sv
module xcvr_byte_latch
  import xcvr_pkg::*;
#(
  parameter int LANES  = DEF_LANES,
  parameter int LANE_W = DEF_LANE_W,
  localparam int BUS_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BUS_W-1:0] aIn,
  input  logic [BUS_W-1:0] bIn,
  input  logic [LANES-1:0] ceAbN,
  input  logic [LANES-1:0] leAbN,
  input  logic [LANES-1:0] oeAbN,
  input  logic [LANES-1:0] ceBaN,
  input  logic [LANES-1:0] leBaN,
  input  logic [LANES-1:0] oeBaN,
  output logic [BUS_W-1:0] aOut,
  output logic [BUS_W-1:0] aOe,
  output logic [BUS_W-1:0] bOut,
  output logic [BUS_W-1:0] bOe
);
  laneStrobe_t [LANES-1:0] strobes;

  xcvr_ctrl #(.LANES(LANES)) u_ctrl (
    .ceAbN  (ceAbN),
    .leAbN  (leAbN),
    .oeAbN  (oeAbN),
    .ceBaN  (ceBaN),
    .leBaN  (leBaN),
    .oeBaN  (oeBaN),
    .strobes(strobes)
  );

  xcvr_datapath #(.LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .aIn    (aIn),
    .bIn    (bIn),
    .aOut   (aOut),
    .aOe    (aOe),
    .bOut   (bOut),
    .bOe    (bOe)
  );
endmodule

// File: rtl/xcvr_byte_latch_chk.sv
module xcvr_byte_latch_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int BUS_W = LANES * LANE_W
) (
  input logic             clk,
  input logic             rstN,
  input logic [BUS_W-1:0] aIn,
  input logic [BUS_W-1:0] bIn,
  input logic [LANES-1:0] ceAbN,
  input logic [LANES-1:0] leAbN,
  input logic [LANES-1:0] oeAbN,
  input logic [LANES-1:0] ceBaN,
  input logic [LANES-1:0] leBaN,
  input logic [LANES-1:0] oeBaN,
  input logic [BUS_W-1:0] aOut,
  input logic [BUS_W-1:0] aOe,
  input logic [BUS_W-1:0] bOut,
  input logic [BUS_W-1:0] bOe
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    p_pass_ab_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!ceAbN[l] && !leAbN[l]) |-> bOut[l*LANE_W +: LANE_W] == aIn[l*LANE_W +: LANE_W]);

    p_capture_ab_r3: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(leAbN[l]) && !$past(ceAbN[l]))
        |-> bOut[l*LANE_W +: LANE_W] == $past(aIn[l*LANE_W +: LANE_W]));

    p_hold_ab_r4: assert property (@(posedge clk) disable iff (!rstN)
      ((ceAbN[l] || leAbN[l]) && $past(ceAbN[l] || leAbN[l]))
        |-> $stable(bOut[l*LANE_W +: LANE_W]));

    p_float_ab_r5: assert property (@(posedge clk) disable iff (!rstN)
      (ceAbN[l] || oeAbN[l]) |-> bOe[l*LANE_W +: LANE_W] == '0);

    p_drive_ab_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!ceAbN[l] && !oeAbN[l]) |-> &bOe[l*LANE_W +: LANE_W]);

    p_pass_ba_r6: assert property (@(posedge clk) disable iff (!rstN)
      (!ceBaN[l] && !leBaN[l]) |-> aOut[l*LANE_W +: LANE_W] == bIn[l*LANE_W +: LANE_W]);

    p_hold_ba_r6: assert property (@(posedge clk) disable iff (!rstN)
      ((ceBaN[l] || leBaN[l]) && $past(ceBaN[l] || leBaN[l]))
        |-> $stable(aOut[l*LANE_W +: LANE_W]));

    p_float_ba_r6: assert property (@(posedge clk) disable iff (!rstN)
      (ceBaN[l] || oeBaN[l]) |-> aOe[l*LANE_W +: LANE_W] == '0);
  end
endmodule

bind xcvr_byte_latch xcvr_byte_latch_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/xcvr_byte_latch_tb.sv
`timescale 1ns/1ps
module xcvr_byte_latch_tb;
  localparam int LANES = 2;
  localparam int LW    = 8;
  localparam int BW    = LANES * LW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [BW-1:0] aIn = '0, bIn = '0;
  logic [LANES-1:0] ceAbN = '1, leAbN = '1, oeAbN = '1;
  logic [LANES-1:0] ceBaN = '1, leBaN = '1, oeBaN = '1;
  logic [BW-1:0] aOut, aOe, bOut, bOe;

  int nVec = 0;
  int nBad = 0;
  logic [BW-1:0] mAb = '0;
  logic [BW-1:0] mBa = '0;

  always #4 clk = ~clk;

  xcvr_byte_latch u_dut (
    .clk(clk), .rstN(rstN), .aIn(aIn), .bIn(bIn),
    .ceAbN(ceAbN), .leAbN(leAbN), .oeAbN(oeAbN),
    .ceBaN(ceBaN), .leBaN(leBaN), .oeBaN(oeBaN),
    .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe)
  );

  function automatic logic [BW-1:0] expData(logic [LANES-1:0] ceN, logic [LANES-1:0] leN,
                                            logic [BW-1:0] din, logic [BW-1:0] held);
    logic [BW-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[l*LW +: LW] = (!ceN[l] && !leN[l]) ? din[l*LW +: LW] : held[l*LW +: LW];
    return r;
  endfunction

  function automatic logic [BW-1:0] expOe(logic [LANES-1:0] ceN, logic [LANES-1:0] oeN);
    logic [BW-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[l*LW +: LW] = {LW{!ceN[l] && !oeN[l]}};
    return r;
  endfunction

  function automatic logic [LANES-1:0] randCtl();
    logic [LANES-1:0] r;
    for (int l = 0; l < LANES; l++) r[l] = ($urandom_range(0, 3) == 0);
    return r;
  endfunction

  task automatic chk(string req, string what, logic [BW-1:0] act, logic [BW-1:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(string req,
                       logic [LANES-1:0] cab, logic [LANES-1:0] lab, logic [LANES-1:0] oab,
                       logic [LANES-1:0] cba, logic [LANES-1:0] lba, logic [LANES-1:0] oba,
                       logic [BW-1:0] a, logic [BW-1:0] b);
    @(negedge clk);
    ceAbN = cab; leAbN = lab; oeAbN = oab;
    ceBaN = cba; leBaN = lba; oeBaN = oba;
    aIn = a; bIn = b;
    #2;
    chk(req, "bOut", bOut, expData(cab, lab, a, mAb));
    chk(req, "bOe",  bOe,  expOe(cab, oab));
    chk(req, "aOut", aOut, expData(cba, lba, b, mBa));
    chk(req, "aOe",  aOe,  expOe(cba, oba));
    mAb = expData(cab, lab, a, mAb);
    mBa = expData(cba, lba, b, mBa);
  endtask

  initial begin
    #(200000 * 8);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    // R1: reset cleared both banks; read with CE low, LE high, OE low
    @(negedge clk);
    rstN = 1'b1;
    apply("R1", 2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'hFFFF, 16'hFFFF);
    // R2 R7: open lane 0 A-to-B only; lane 1 stays at reset value
    apply("R2/R7", 2'b10, 2'b10, 2'b00, 2'b11, 2'b11, 2'b11, 16'h5AA5, 16'h1111);
    // R3: latch enable rises, A changes; lane 0 keeps 0xA5
    apply("R3", 2'b10, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 16'hC33C, 16'h2222);
    apply("R3", 2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 16'h0F0F, 16'h3333);
    // R4 R5: CE high with LE low holds and floats
    apply("R4/R5", 2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 16'h7E81, 16'h4444);
    apply("R4", 2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 16'h9999, 16'h5555);
    // R5: OE high with CE low floats
    apply("R5", 2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 16'h1234, 16'h6666);
    // R6 R7: B-to-A lane 1 only, A-to-B bank untouched
    apply("R6/R7", 2'b11, 2'b11, 2'b11, 2'b01, 2'b01, 2'b00, 16'hAAAA, 16'hBEEF);
    apply("R6", 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 2'b00, 16'hAAAA, 16'h0000);
    apply("R7", 2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'h0000, 16'h0000);
    // random mix R2/R3/R4/R5/R6/R7
    for (int i = 0; i < 800; i++)
      apply("rand R2/R3/R4/R5/R6/R7", randCtl(), randCtl(), randCtl(),
            randCtl(), randCtl(), randCtl(), 16'($urandom), 16'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule